// File: doc/BRIEF.md
# Streaming Polynomial Flat-Field Generator

This block sits in a grayscale video pipeline and turns each incoming pixel beat into two aligned outputs: the original pixel, passed through unchanged, and a synthetic flat-field pixel. The flat-field value is a second-order surface in the pixel's column and row, evaluated in fixed point with six signed coefficients. A downstream stage can divide the live image by this surface to correct uneven illumination. Column and row are not supplied with the stream. The block works them out from the data-valid, line-end and frame-end flags that travel with every beat.

Six coefficients, an image width and an image height arrive on a configuration port. The block captures them on the first beat of each frame and holds them for the rest of that frame, so the host may rewrite them at any time. Both sides of the block use a valid/ready handshake. The ready the block gives upstream is honoured one cycle late: a beat offered in the cycle after the block lowered its ready is discarded. A one-entry holding slot covers the beat that can be in flight when downstream stalls. In steady state the block takes one beat per clock, and a beat reaches the outputs a fixed number of cycles later.

Top module: `flat_surface_gen`

## Requirements
- R1: With `outReady` held high and nothing buffered, a beat accepted in cycle t appears in cycle t+LATENCY (default 46) with `outValid` high, with the same pixel value and the same data-valid, line-end and frame-end flags. One set of output flags serves both the pass-through pixel and the flat-field pixel.
- R2: The flat-field pixel is S = c0 + c1·x + c2·y + c3·x² + c4·x·y + c5·y². x is the beat's column and y is its row. Each ck is a signed Q8.16 value taken from bits [24k+23:24k] of `cfgCoef`.
- R3: S is rounded to the nearest integer, with halves rounded up, and then clamped to the range 0 to 2^PIX_W−1.
- R4: A beat takes the current (column, row) as its position. A data-valid beat then advances the column. A line-end beat sets the column to 0 and advances the row. A frame-end beat sets both to 0. The first position of every frame is (0,0).
- R5: The column never passes width−1 and the row never passes height−1. Extra pixels or lines keep the last position.
- R6: Width, height and coefficients are captured on the first beat after reset or after a frame-end beat. Changes during a frame have no effect until the next frame.
- R7: `outValid` is low in every cycle in which `outReady` is low. Stalls do not lose, duplicate or reorder beats.
- R8: If `inReady` is low in cycle t, a beat offered in cycle t+1 is discarded. It never reaches the outputs and does not move the position.
- R9: A beat with data-valid, line-end and frame-end all low leaves the position unchanged. It still passes through, with its flags, in its place in the stream.
- R10: Beats accepted in consecutive cycles leave in consecutive cycles (one beat per clock).
- R11: After reset `outValid` is low. `inReady` equals `outReady` whenever the holding slot is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Upstream offers a beat |
| inReady | output | 1 | Block can take a beat in the next cycle |
| inPix | input | PIX_W | Input pixel value |
| inDataValid | input | 1 | Beat carries a usable pixel |
| inLineEnd | input | 1 | Beat closes a line |
| inFrameEnd | input | 1 | Beat closes a frame |
| cfgWidth | input | DIM_W | Image width in pixels |
| cfgHeight | input | DIM_W | Image height in lines |
| cfgCoef | input | 6·COEF_W | Six Q8.16 coefficients, c0 in the low bits |
| outReady | input | 1 | Downstream can take a beat |
| outValid | output | 1 | Output beat present |
| outPix | output | PIX_W | Passed-through pixel |
| outSurf | output | PIX_W | Flat-field pixel |
| outDataValid | output | 1 | Data-valid flag of the output beat |
| outLineEnd | output | 1 | Line-end flag of the output beat |
| outFrameEnd | output | 1 | Frame-end flag of the output beat |

## Verification
Some properties are checked on every cycle. The holding slot never takes a second beat. A beat offered after a low ready is never loaded. The position counters restart after line-end and frame-end beats, and the column stays inside the captured width. The output registers stay frozen while downstream stalls, and an idle input cycle leaves a bubble in the first stage. Other behaviour shows only in the bench's scenarios: the surface arithmetic, including rounding and clamping at both ends; the exact latency; back-to-back throughput; capture of the configuration only at frame starts; and the promise that no beat is lost, duplicated or reordered under irregular stall patterns and a source that ignores the ready rule. The bench checks each of these against an arithmetic model of the surface and the position counters.

// File: rtl/flat_surface_pkg.sv
package flat_surface_pkg;
  localparam int COEF_N = 6;

  typedef struct packed {
    logic dataValid;
    logic lineEnd;
    logic frameEnd;
  } marks_t;

  typedef struct packed {
    logic advance;  // whole pipeline moves one stage
    logic load;     // a beat enters stage 0 on this advance
  } strobe_t;
endpackage

// File: rtl/flat_surface_ctrl.sv
module flat_surface_ctrl
  import flat_surface_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int POS_W  = 16,
  parameter int COEF_W = 24,
  parameter int DIM_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      inValid,
  output logic                      inReady,
  input  logic [PIX_W-1:0]          inPix,
  input  marks_t                    inMarks,
  input  logic                      outReady,
  input  logic [DIM_W-1:0]          cfgWidth,
  input  logic [DIM_W-1:0]          cfgHeight,
  input  logic [COEF_N*COEF_W-1:0]  cfgCoef,
  output strobe_t                   strb,
  output logic [PIX_W-1:0]          beatPix,
  output marks_t                    beatMarks,
  output logic [POS_W-1:0]          posX,
  output logic [POS_W-1:0]          posY,
  output logic [COEF_N*COEF_W-1:0]  coefUse
);
  localparam int EXT_W = DIM_W + 1;

  logic readyPrev, skidFull, accept, startPending;
  logic [PIX_W-1:0] skidPix;
  marks_t skidMarks;
  logic [POS_W-1:0] colQ, rowQ;
  logic [DIM_W-1:0] heldW, heldH, effW, effH;
  logic [COEF_N*COEF_W-1:0] heldCoef;
  logic [EXT_W-1:0] colNext, rowNext;
  logic colCanStep, rowCanStep;

  // A beat counts only if ready was high in the previous cycle.
  assign accept      = inValid & readyPrev;
  assign inReady     = outReady & ~skidFull;
  assign strb.advance = outReady;
  assign strb.load   = outReady & (skidFull | accept);
  assign beatPix     = skidFull ? skidPix : inPix;
  assign beatMarks   = skidFull ? skidMarks : inMarks;

  assign effW    = startPending ? cfgWidth  : heldW;
  assign effH    = startPending ? cfgHeight : heldH;
  assign coefUse = startPending ? cfgCoef   : heldCoef;
  assign posX    = colQ;
  assign posY    = rowQ;

  assign colNext    = EXT_W'(colQ) + EXT_W'(1);
  assign rowNext    = EXT_W'(rowQ) + EXT_W'(1);
  assign colCanStep = (colNext < {1'b0, effW}) && (colQ != '1);
  assign rowCanStep = (rowNext < {1'b0, effH}) && (rowQ != '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      readyPrev <= 1'b0;
      skidFull  <= 1'b0;
      skidPix   <= '0;
      skidMarks <= '0;
    end else begin
      readyPrev <= inReady;
      if (accept && !strb.advance) begin
        skidFull  <= 1'b1;
        skidPix   <= inPix;
        skidMarks <= inMarks;
      end else if (strb.advance && skidFull) begin
        skidFull <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      colQ         <= '0;
      rowQ         <= '0;
      startPending <= 1'b1;
      heldW        <= '0;
      heldH        <= '0;
      heldCoef     <= '0;
    end else if (strb.load) begin
      if (startPending) begin
        heldW    <= cfgWidth;
        heldH    <= cfgHeight;
        heldCoef <= cfgCoef;
      end
      startPending <= beatMarks.frameEnd;
      if (beatMarks.frameEnd) begin
        colQ <= '0;
        rowQ <= '0;
      end else if (beatMarks.lineEnd) begin
        colQ <= '0;
        if (rowCanStep) rowQ <= rowQ + 1'b1;
      end else if (beatMarks.dataValid && colCanStep) begin
        colQ <= colQ + 1'b1;
      end
    end
  end

  p_skid_single_r7: assert property (@(posedge clk) disable iff (rst)
    skidFull |-> !accept);
  p_drop_late_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(!inReady) && !skidFull) |-> !strb.load);
  p_line_restart_r4: assert property (@(posedge clk) disable iff (rst)
    (strb.load && beatMarks.lineEnd) |=> (colQ == '0));
  p_frame_restart_r4: assert property (@(posedge clk) disable iff (rst)
    (strb.load && beatMarks.frameEnd) |=> (colQ == '0 && rowQ == '0 && startPending));
  p_col_clamp_r5: assert property (@(posedge clk) disable iff (rst)
    (!startPending && heldW != '0) |-> (DIM_W'(colQ) < heldW));
endmodule

// File: rtl/flat_surface_dp.sv
module flat_surface_dp
  import flat_surface_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int POS_W   = 16,
  parameter int COEF_W  = 24,
  parameter int FRAC_W  = 16,
  parameter int LATENCY = 46
) (
  input  logic                      clk,
  input  logic                      rst,
  input  strobe_t                   strb,
  input  logic [PIX_W-1:0]          beatPix,
  input  marks_t                    beatMarks,
  input  logic [POS_W-1:0]          posX,
  input  logic [POS_W-1:0]          posY,
  input  logic [COEF_N*COEF_W-1:0]  coefUse,
  output logic                      outLive,
  output logic [PIX_W-1:0]          outPix,
  output logic [PIX_W-1:0]          outSurf,
  output marks_t                    outMarks
);
  localparam int SQ_W   = 2 * POS_W;
  localparam int ACC_W  = COEF_W + SQ_W + 4;
  localparam int DLY    = LATENCY - 4;
  localparam int BEAT_W = 1 + 2 * PIX_W + 3;
  localparam logic signed [ACC_W-1:0] HALF   = ACC_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [ACC_W-1:0] PIXMAX = ACC_W'((1 << PIX_W) - 1);

  function automatic logic signed [ACC_W-1:0] mulTerm(
      input logic [COEF_W-1:0] coef, input logic [SQ_W-1:0] val);
    logic signed [ACC_W-1:0] a, b;
    a = {{(ACC_W-COEF_W){coef[COEF_W-1]}}, coef};
    b = {{(ACC_W-SQ_W){1'b0}}, val};
    return a * b;
  endfunction

  // stage 0: beat, position and coefficient snapshot
  logic v0, v1, v2, v3;
  logic [PIX_W-1:0] pix0, pix1, pix2, pix3, surf3;
  marks_t m0, m1, m2, m3;
  logic [POS_W-1:0] x0, y0;
  logic [COEF_N*COEF_W-1:0] coef0, coef1;
  logic [SQ_W-1:0] opnd [COEF_N];
  logic signed [ACC_W-1:0] term [COEF_N];
  logic signed [ACC_W-1:0] sumC, shiftC;

  always_ff @(posedge clk) begin
    if (rst) begin
      v0 <= 1'b0; pix0 <= '0; m0 <= '0; x0 <= '0; y0 <= '0; coef0 <= '0;
      v1 <= 1'b0; pix1 <= '0; m1 <= '0; coef1 <= '0;
      v2 <= 1'b0; pix2 <= '0; m2 <= '0;
      v3 <= 1'b0; pix3 <= '0; m3 <= '0; surf3 <= '0;
      for (int k = 0; k < COEF_N; k++) opnd[k] <= '0;
    end else if (strb.advance) begin
      v0 <= strb.load; pix0 <= beatPix; m0 <= beatMarks;
      x0 <= posX; y0 <= posY; coef0 <= coefUse;
      // stage 1: operands of the six terms
      v1 <= v0; pix1 <= pix0; m1 <= m0; coef1 <= coef0;
      opnd[0] <= SQ_W'(1);
      opnd[1] <= SQ_W'(x0);
      opnd[2] <= SQ_W'(y0);
      opnd[3] <= SQ_W'(x0) * SQ_W'(x0);
      opnd[4] <= SQ_W'(x0) * SQ_W'(y0);
      opnd[5] <= SQ_W'(y0) * SQ_W'(y0);
      // stage 2: products (below); stage 3: round and clamp
      v2 <= v1; pix2 <= pix1; m2 <= m1;
      v3 <= v2; pix3 <= pix2; m3 <= m2;
      if (sumC[ACC_W-1])      surf3 <= '0;
      else if (shiftC > PIXMAX) surf3 <= '1;
      else                    surf3 <= shiftC[PIX_W-1:0];
    end
  end

  for (genvar k = 0; k < COEF_N; k++) begin : g_term
    always_ff @(posedge clk) begin
      if (rst) term[k] <= '0;
      else if (strb.advance) term[k] <= mulTerm(coef1[k*COEF_W +: COEF_W], opnd[k]);
    end
  end

  always_comb begin
    sumC = HALF;
    for (int k = 0; k < COEF_N; k++) sumC = sumC + term[k];
    shiftC = sumC >>> FRAC_W;
  end

  // plain delay line to reach the configured latency
  logic [BEAT_W-1:0] head;
  logic [BEAT_W-1:0] dlyQ [DLY];
  assign head = {v3, pix3, surf3, m3};

  for (genvar g = 0; g < DLY; g++) begin : g_dly
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) dlyQ[g] <= '0;
        else if (strb.advance) dlyQ[g] <= head;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) dlyQ[g] <= '0;
        else if (strb.advance) dlyQ[g] <= dlyQ[g-1];
      end
    end
  end

  assign {outLive, outPix, outSurf, outMarks} = dlyQ[DLY-1];

  p_hold_on_stall_r7: assert property (@(posedge clk) disable iff (rst)
    !strb.advance |=> ($stable(outLive) && $stable(outPix) && $stable(outSurf)));
  p_bubble_r10: assert property (@(posedge clk) disable iff (rst)
    (strb.advance && !strb.load) |=> !v0);
endmodule

// File: rtl/flat_surface_gen.sv
module flat_surface_gen
  import flat_surface_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int POS_W   = 16,
  parameter int COEF_W  = 24,
  parameter int FRAC_W  = 16,
  parameter int DIM_W   = 32,
  parameter int LATENCY = 46
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      inValid,
  output logic                      inReady,
  input  logic [PIX_W-1:0]          inPix,
  input  logic                      inDataValid,
  input  logic                      inLineEnd,
  input  logic                      inFrameEnd,
  input  logic [DIM_W-1:0]          cfgWidth,
  input  logic [DIM_W-1:0]          cfgHeight,
  input  logic [COEF_N*COEF_W-1:0]  cfgCoef,
  input  logic                      outReady,
  output logic                      outValid,
  output logic [PIX_W-1:0]          outPix,
  output logic [PIX_W-1:0]          outSurf,
  output logic                      outDataValid,
  output logic                      outLineEnd,
  output logic                      outFrameEnd
);
  strobe_t strb;
  marks_t inMarks, beatMarks, outMarks;
  logic [PIX_W-1:0] beatPix;
  logic [POS_W-1:0] posX, posY;
  logic [COEF_N*COEF_W-1:0] coefUse;
  logic outLive;

  assign inMarks = '{dataValid: inDataValid, lineEnd: inLineEnd, frameEnd: inFrameEnd};

  flat_surface_ctrl #(.PIX_W(PIX_W), .POS_W(POS_W), .COEF_W(COEF_W), .DIM_W(DIM_W)) ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inPix(inPix),
    .inMarks(inMarks), .outReady(outReady), .cfgWidth(cfgWidth), .cfgHeight(cfgHeight),
    .cfgCoef(cfgCoef), .strb(strb), .beatPix(beatPix), .beatMarks(beatMarks),
    .posX(posX), .posY(posY), .coefUse(coefUse));

  flat_surface_dp #(.PIX_W(PIX_W), .POS_W(POS_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W),
                    .LATENCY(LATENCY)) dp (
    .clk(clk), .rst(rst), .strb(strb), .beatPix(beatPix), .beatMarks(beatMarks),
    .posX(posX), .posY(posY), .coefUse(coefUse), .outLive(outLive), .outPix(outPix),
    .outSurf(outSurf), .outMarks(outMarks));

  assign outValid     = outLive & outReady;
  assign outDataValid = outMarks.dataValid;
  assign outLineEnd   = outMarks.lineEnd;
  assign outFrameEnd  = outMarks.frameEnd;
endmodule

// File: tb/flat_surface_gen_test.sv
`timescale 1ns/1ps
module flat_surface_gen_test;
  localparam int LAT = 46;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0, inDv = 1'b0, inEol = 1'b0, inEoi = 1'b0;
  logic [7:0] inPix = '0;
  logic [31:0] cfgW = 32'd6, cfgH = 32'd4;
  logic [143:0] cfgCoef = '0;
  logic outReady = 1'b1;
  logic inReady, outValid, outDv, outEol, outEoi;
  logic [7:0] outPix, outSurf;

  always #2.5 clk = ~clk;

  flat_surface_gen uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inPix(inPix),
    .inDataValid(inDv), .inLineEnd(inEol), .inFrameEnd(inEoi), .cfgWidth(cfgW),
    .cfgHeight(cfgH), .cfgCoef(cfgCoef), .outReady(outReady), .outValid(outValid),
    .outPix(outPix), .outSurf(outSurf), .outDataValid(outDv), .outLineEnd(outEol),
    .outFrameEnd(outEoi));

  typedef struct { int pix; bit dv, eol, eoi; } beat_t;
  typedef struct { int pix, surf; bit dv, eol, eoi; int cyc; } exp_t;

  beat_t stimQ[$];
  exp_t  expQ[$];
  int nTests = 0, nFail = 0, cyc = 0;
  bit prevReady = 0;
  // bench model state
  int col = 0, row = 0, hW = 0, hH = 0;
  bit pending = 1;
  longint hc[6];
  longint cc[6];

  task automatic check(input bit ok, input string req, input string what,
                       input longint got, input longint expv);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, expv);
    end
  endtask

  task automatic setCfg(input int w, input int h, input longint c0, input longint c1,
                        input longint c2, input longint c3, input longint c4, input longint c5);
    cc[0] = c0; cc[1] = c1; cc[2] = c2; cc[3] = c3; cc[4] = c4; cc[5] = c5;
    cfgW = w; cfgH = h;
    for (int k = 0; k < 6; k++) cfgCoef[k*24 +: 24] = cc[k][23:0];
  endtask

  function automatic int surface(input int x, input int y);
    longint s, r;
    s = hc[0] + hc[1]*x + hc[2]*y + hc[3]*x*x + hc[4]*x*y + hc[5]*y*y;
    r = (s + 32768) >>> 16;
    if (r < 0) r = 0;
    if (r > 255) r = 255;
    return int'(r);
  endfunction

  task automatic modelAccept(input beat_t b);
    exp_t e;
    if (pending) begin
      hW = int'(cfgW); hH = int'(cfgH);
      for (int k = 0; k < 6; k++) hc[k] = cc[k];
      pending = 0;
    end
    e.pix = b.pix; e.dv = b.dv; e.eol = b.eol; e.eoi = b.eoi; e.cyc = cyc;
    e.surf = surface(col, row);
    expQ.push_back(e);
    if (b.eoi) begin col = 0; row = 0; pending = 1; end
    else if (b.eol) begin col = 0; if (row + 1 < hH) row++; end
    else if (b.dv) begin if (col + 1 < hW) col++; end
  endtask

  task automatic addFrame(input int lines, input int perLine, input bit sepEol,
                          input int idleEvery, input int seed);
    beat_t b;
    for (int y = 0; y < lines; y++) begin
      for (int x = 0; x < perLine; x++) begin
        b.pix = (y*37 + x*11 + seed) & 255; b.dv = 1;
        b.eol = !sepEol && (x == perLine-1);
        b.eoi = b.eol && (y == lines-1);
        stimQ.push_back(b);
        if (idleEvery > 0 && (x % idleEvery) == 0) begin
          b.pix = 77; b.dv = 0; b.eol = 0; b.eoi = 0;
          stimQ.push_back(b);
        end
      end
      if (sepEol) begin
        b.pix = 0; b.dv = 0; b.eol = 1; b.eoi = (y == lines-1);
        stimQ.push_back(b);
      end
    end
  endtask

  // one clock: drive, then sample, then update model
  int firstPop, lastPop, popCount, accCount;
  task automatic tick(input string tag, input bit rude, input int stallMode, input bit chkLat,
                      input int swapAt);
    beat_t b;
    bit offered;
    exp_t e;
    @(posedge clk);
    cyc++;
    #1;
    case (stallMode)
      1: outReady = (cyc % 3) != 0;
      2: outReady = ((cyc / 4) % 3) != 0;
      default: outReady = 1'b1;
    endcase
    offered = 0;
    if (stimQ.size() > 0 && (rude || prevReady)) begin
      b = stimQ.pop_front();
      offered = 1;
      inValid = 1; inPix = b.pix[7:0]; inDv = b.dv; inEol = b.eol; inEoi = b.eoi;
    end else begin
      inValid = 0; inDv = 0; inEol = 0; inEoi = 0;
    end
    if (swapAt > 0 && accCount == swapAt)
      setCfg(6, 4, 688128, 212992, -1310720, 65536, -49152, 131072);
    #1;
    if (!outReady) check(outValid == 1'b0, "R7", "outValid while stalled", outValid, 0);
    if (outValid) begin
      if (expQ.size() == 0) begin
        check(0, tag, "unexpected output beat pix", outPix, -1);
      end else begin
        e = expQ.pop_front();
        popCount++;
        if (popCount == 1) firstPop = cyc;
        lastPop = cyc;
        check(outPix == e.pix[7:0] && outDv == e.dv && outEol == e.eol && outEoi == e.eoi,
              tag, "R1 pass-through pix/flags",
              {outPix, 1'b0, outDv, outEol, outEoi},
              {e.pix[7:0], 1'b0, e.dv, e.eol, e.eoi});
        check(outSurf == e.surf[7:0], tag, "R2 R3 surface", outSurf, e.surf);
        if (chkLat) check(cyc - e.cyc == LAT, "R1", "latency", cyc - e.cyc, LAT);
      end
    end
    if (offered && prevReady) begin
      modelAccept(b);
      accCount++;
    end
    prevReady = inReady;
  endtask

  task automatic runScenario(input string tag, input bit rude, input int stallMode,
                             input bit chkLat, input int swapAt);
    int guard = 0;
    popCount = 0; accCount = 0;
    while ((stimQ.size() > 0 || expQ.size() > 0) && guard < 6000) begin
      tick(tag, rude, stallMode, chkLat, swapAt);
      guard++;
    end
    check(expQ.size() == 0, "R7", {tag, " beats left undelivered"}, expQ.size(), 0);
    for (int i = 0; i < 4; i++) tick(tag, 0, 0, 0, 0);
  endtask

  initial begin
    setCfg(6, 4, 688128, 212992, -1310720, 65536, -49152, 131072);
    for (int i = 0; i < 4; i++) tick("R11", 0, 0, 0, 0);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick("R11", 0, 0, 0, 0);
      check(outValid == 1'b0, "R11", "outValid after reset", outValid, 0);
      check(inReady == outReady, "R11", "inReady follows outReady", inReady, outReady);
    end

    // A: continuous stream, exact latency and throughput
    addFrame(4, 6, 0, 0, 3);
    runScenario("R1 R2 R3 R10", 0, 0, 1, 0);
    check(lastPop - firstPop == 23, "R10", "output spread of 24 beats", lastPop - firstPop, 23);

    // B: saturating coefficients, rewritten mid-frame; second frame picks them up
    setCfg(6, 4, 7880704, 1966080, 360448, 32768, 0, -65536);
    addFrame(4, 6, 0, 0, 9);
    addFrame(4, 6, 0, 0, 21);
    runScenario("R6 R3", 0, 0, 1, 5);

    // C: downstream stalls in two patterns
    setCfg(6, 4, 32768, 65536, 1048576, 0, 0, 0);
    addFrame(4, 6, 0, 0, 40);
    runScenario("R7 R4", 0, 2, 0, 0);
    addFrame(4, 6, 0, 0, 50);
    runScenario("R7 R4", 0, 1, 0, 0);

    // D: source ignoring ready: late beats must vanish
    addFrame(4, 6, 0, 0, 60);
    addFrame(4, 6, 0, 0, 70);
    runScenario("R8", 1, 1, 0, 0);

    // E: separate line-end beats, idle beats, overlong lines and extra lines
    setCfg(4, 3, 32768, 65536, 1048576, 0, 0, 0);
    addFrame(5, 6, 1, 2, 80);
    runScenario("R4 R5 R9", 0, 0, 1, 0);
    addFrame(5, 6, 1, 3, 90);
    runScenario("R4 R5 R9 R7", 0, 2, 0, 0);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    nFail++;
    nTests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule